// File: doc/BRIEF.md
# Serial SRAM Host Controller

This block lets on-chip logic use a byte-addressed serial SRAM over a four-wire SPI link (clock, data out, data in, active-low select). The local side takes one command at a time: a read or a write of any length from a 16-bit start address, a query of the memory's size, or a clear that fills the whole memory with zeros. Write data enters through a valid/ready stream. Read data leaves through a valid/ready stream. Either stream may stall, and the controller waits for it. While waiting, the serial clock stays low and the select line stays asserted.

After reset the controller prepares the memory before it accepts any command. It waits with select high, then pulses select low once without clocking. It then writes the memory's status register with the value that selects linear addressing with the pause input disabled. Every transaction is one select-low window. The window holds an opcode, then a big-endian address for reads and writes, then the data bytes back to back. The serial clock is the system clock divided by `2*CLK_DIV`. For a 20 MHz memory, `CLK_DIV` must be large enough to keep the serial clock at or below that rate.

A size query returns a code byte, which is mapped to a byte count. A clear runs the query first and then streams exactly that many zero bytes from address 0. The unit size is a parameter (`UNIT_LOG2`, default 13, which gives 8 KB).

Top module: `spi_sram_ctrl`

## Requirements
- R1: During and after reset, cs_n is high, sclk is low, done and rd_valid are low, and cmd_ready stays low until initialisation completes.
- R2: Initialisation happens exactly once. It is one select-low window with no sclk edges, followed by one window carrying opcode OPC_WRSR (default 0x01) and then CFG_VALUE (default 0x41). Only after that does cmd_ready rise.
- R3: The link runs in SPI mode 0. sclk idles low, bytes go most significant bit first, mosi changes only while sclk is low, and miso is sampled on the rising edge. Each sclk high phase lasts exactly CLK_DIV system clocks.
- R4: cs_n stays high for at least 2*CLK_DIV system clocks between select windows, and sclk never toggles while cs_n is high.
- R5: The write command (cmd_op = 1) sends OPC_WRITE (default 0x02), the address high byte, the address low byte, and then cmd_len bytes taken from the write stream, all in one window. A byte is taken only when wr_valid and wr_ready are both high. wr_ready is high only when the controller can shift that byte out at once.
- R6: The read command (cmd_op = 0) sends OPC_READ (default 0x03) and the two address bytes, then one 0x00 byte for each byte read. Each byte captured on miso appears on rd_data with rd_valid. rd_data stays stable until rd_ready is high. The next dummy byte does not start while a byte is waiting.
- R7: A read or write with cmd_len = 0 sends only the opcode and the two address bytes, then ends the window.
- R8: The size query (cmd_op = 2) sends OPC_MODEID (default 0x15) and then 0xFF. The returned code k sets size_bytes to 2^(UNIT_LOG2+k) for k in 0..3, and to 0 for any other code.
- R9: The clear command (cmd_op = 3) runs the size query. It then runs one write window at address 0x0000 carrying size_bytes zero bytes. A size of 0 gives a header-only window.
- R10: A command is accepted when cmd_valid and cmd_ready are both high. cmd_ready equals !busy. A command presented while busy has no effect. done pulses for one cycle, with cs_n high, when the last window of a command has closed and its select-high gap has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken (not busy) |
| cmd_op | input | 2 | 0 read, 1 write, 2 size query, 3 clear |
| cmd_addr | input | 16 | Start address |
| cmd_len | input | LEN_W | Number of data bytes for read or write |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Write byte taken this cycle when valid |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Initialising or running a command |
| done | output | 1 | One-cycle completion pulse |
| size_bytes | output | UNIT_LOG2+4 | Size from the last query |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the memory |
| miso | input | 1 | Serial data from the memory |
| cs_n | output | 1 | Active-low chip select |

## Verification
A wrong byte counter or header index shows at once as a select window whose bit count is not 24 + 8*len. The memory model sees it when the window closes, within one transaction. A corrupted data path shows as a mismatched memory cell or read byte, which is compared at the end of that transaction. A stuck sequencer state leaves cmd_ready low or done missing, which the next command exposes within a few hundred cycles. A divider or gap fault changes the measured sclk high time or select gap on the very next byte.

// File: rtl/spisram_pkg.sv
package spisram_pkg;

  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_SIZE  = 2'd2,
    CMD_CLEAR = 2'd3
  } cmd_op_e;

  typedef enum logic [2:0] {
    XK_CFG,
    XK_READ,
    XK_WRITE,
    XK_SIZE,
    XK_FILL
  } xfer_kind_e;

  typedef enum logic [2:0] {
    ST_BOOT_HI,
    ST_BOOT_LO,
    ST_BOOT_GAP,
    ST_IDLE,
    ST_XFER,
    ST_GAP
  } seq_state_e;

endpackage

// File: rtl/spisram_shifter.sv
module spisram_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       byte_done,
  output logic       active
);

  localparam int DIV_W = $clog2(CLK_DIV + 1);

  logic [DIV_W-1:0] div_cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       tx_sh;
  logic [7:0]       rx_sh;
  logic             sclk_q;
  logic             done_q;
  logic             act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bit_idx <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (start) begin
          act_q   <= 1'b1;
          tx_sh   <= tx_byte;
          bit_idx <= '0;
          div_cnt <= '0;
          sclk_q  <= 1'b0;
        end
      end else if (div_cnt == DIV_W'(CLK_DIV - 1)) begin
        div_cnt <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_sh  <= {rx_sh[6:0], miso};
        end else begin
          sclk_q <= 1'b0;
          if (bit_idx == 3'd7) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 3'd1;
            tx_sh   <= {tx_sh[6:0], 1'b0};
          end
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end

  assign sclk      = sclk_q;
  assign mosi      = tx_sh[7];
  assign rx_byte   = rx_sh;
  assign byte_done = done_q;
  assign active    = act_q;

  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> $stable(tx_sh[7])); // R3

endmodule

// File: rtl/spisram_sizemap.sv
module spisram_sizemap #(
  parameter int UNIT_LOG2 = 13
) (
  input  logic [7:0]           code,
  output logic [UNIT_LOG2+3:0] bytes
);

  always_comb begin
    bytes = '0;
    for (int k = 0; k < 4; k++) begin
      if (code == 8'(k)) bytes = (UNIT_LOG2 + 4)'(1) << (UNIT_LOG2 + k);
    end
  end

endmodule

// File: rtl/spisram_seq.sv
module spisram_seq
  import spisram_pkg::*;
#(
  parameter int         CLK_DIV    = 2,
  parameter int         LEN_W      = 17,
  parameter int         UNIT_LOG2  = 13,
  parameter logic [7:0] OPC_READ   = 8'h03,
  parameter logic [7:0] OPC_WRITE  = 8'h02,
  parameter logic [7:0] OPC_WRSR   = 8'h01,
  parameter logic [7:0] OPC_MODEID = 8'h15,
  parameter logic [7:0] CFG_VALUE  = 8'h41
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [1:0]           cmd_op,
  input  logic [15:0]          cmd_addr,
  input  logic [LEN_W-1:0]     cmd_len,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [7:0]           wr_data,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [7:0]           rd_data,
  output logic                 busy,
  output logic                 done,
  output logic [UNIT_LOG2+3:0] size_bytes,
  output logic                 cs_n,
  output logic                 sh_start,
  output logic [7:0]           sh_tx,
  input  logic                 sh_active,
  input  logic                 sh_done,
  input  logic [7:0]           sh_rx
);

  localparam int GAP_CYC = 2 * CLK_DIV;
  localparam int GAP_W   = $clog2(GAP_CYC) + 1;
  localparam int SZ_W    = UNIT_LOG2 + 4;
  localparam int CNT_W   = (LEN_W > SZ_W) ? LEN_W : SZ_W;

  seq_state_e       st;
  xfer_kind_e       kind;
  logic             cs_q;
  logic [GAP_W-1:0] gap_cnt;
  logic [1:0]       hdr_idx;
  logic [CNT_W-1:0] left;
  logic [15:0]      addr_q;
  logic             chain_fill;
  logic             flight_data;
  logic             rdv_q;
  logic [7:0]       rdd_q;
  logic [SZ_W-1:0]  size_q;
  logic [SZ_W-1:0]  size_map;
  logic             done_q;

  logic       gap_end;
  logic [1:0] hdr_len;
  logic       in_hdr;
  logic [7:0] opc_byte;
  logic [7:0] hdr_byte;
  logic [7:0] dat_byte;
  logic       can_issue;
  logic       start_c;
  logic       finish_c;
  logic       wr_rdy_c;

  spisram_sizemap #(.UNIT_LOG2(UNIT_LOG2)) u_map (
    .code  (sh_rx),
    .bytes (size_map)
  );

  assign gap_end = (gap_cnt == GAP_W'(GAP_CYC - 1));

  always_comb begin
    hdr_len = (kind == XK_READ || kind == XK_WRITE || kind == XK_FILL) ? 2'd3 : 2'd1;
    in_hdr  = (hdr_idx < hdr_len);
    case (kind)
      XK_CFG:  opc_byte = OPC_WRSR;
      XK_SIZE: opc_byte = OPC_MODEID;
      XK_READ: opc_byte = OPC_READ;
      default: opc_byte = OPC_WRITE;
    endcase
    case (hdr_idx)
      2'd0:    hdr_byte = opc_byte;
      2'd1:    hdr_byte = addr_q[15:8];
      default: hdr_byte = addr_q[7:0];
    endcase
    case (kind)
      XK_CFG:   dat_byte = CFG_VALUE;
      XK_SIZE:  dat_byte = 8'hFF;
      XK_WRITE: dat_byte = wr_data;
      default:  dat_byte = 8'h00;
    endcase
  end

  always_comb begin
    can_issue = (st == ST_XFER) && !sh_active;
    start_c   = 1'b0;
    finish_c  = 1'b0;
    wr_rdy_c  = 1'b0;
    if (can_issue) begin
      if (in_hdr) begin
        start_c = 1'b1;
      end else if (left != '0) begin
        case (kind)
          XK_WRITE: begin
            wr_rdy_c = 1'b1;
            start_c  = wr_valid;
          end
          XK_READ: start_c = !rdv_q && !sh_done;
          default: start_c = 1'b1;
        endcase
      end else begin
        finish_c = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_BOOT_HI;
      kind        <= XK_CFG;
      cs_q        <= 1'b1;
      gap_cnt     <= '0;
      hdr_idx     <= '0;
      left        <= '0;
      addr_q      <= '0;
      chain_fill  <= 1'b0;
      flight_data <= 1'b0;
      rdv_q       <= 1'b0;
      rdd_q       <= '0;
      size_q      <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rdv_q && rd_ready) rdv_q <= 1'b0;
      if (sh_done && flight_data) begin
        if (kind == XK_READ) begin
          rdd_q <= sh_rx;
          rdv_q <= 1'b1;
        end
        if (kind == XK_SIZE) size_q <= size_map;
      end
      case (st)
        ST_BOOT_HI: begin
          gap_cnt <= gap_cnt + GAP_W'(1);
          if (gap_end) begin
            gap_cnt <= '0;
            cs_q    <= 1'b0;
            st      <= ST_BOOT_LO;
          end
        end
        ST_BOOT_LO: begin
          gap_cnt <= gap_cnt + GAP_W'(1);
          if (gap_end) begin
            gap_cnt <= '0;
            cs_q    <= 1'b1;
            st      <= ST_BOOT_GAP;
          end
        end
        ST_BOOT_GAP: begin
          gap_cnt <= gap_cnt + GAP_W'(1);
          if (gap_end) begin
            gap_cnt <= '0;
            kind    <= XK_CFG;
            left    <= CNT_W'(1);
            hdr_idx <= '0;
            cs_q    <= 1'b0;
            st      <= ST_XFER;
          end
        end
        ST_IDLE: begin
          if (cmd_valid) begin
            addr_q     <= cmd_addr;
            hdr_idx    <= '0;
            cs_q       <= 1'b0;
            st         <= ST_XFER;
            chain_fill <= (cmd_op_e'(cmd_op) == CMD_CLEAR);
            case (cmd_op_e'(cmd_op))
              CMD_READ: begin
                kind <= XK_READ;
                left <= CNT_W'(cmd_len);
              end
              CMD_WRITE: begin
                kind <= XK_WRITE;
                left <= CNT_W'(cmd_len);
              end
              default: begin
                kind <= XK_SIZE;
                left <= CNT_W'(1);
              end
            endcase
          end
        end
        ST_XFER: begin
          if (start_c) begin
            flight_data <= !in_hdr;
            if (in_hdr) hdr_idx <= hdr_idx + 2'd1;
            else        left    <= left - CNT_W'(1);
          end
          if (finish_c) begin
            cs_q    <= 1'b1;
            gap_cnt <= '0;
            st      <= ST_GAP;
          end
        end
        default: begin
          gap_cnt <= gap_cnt + GAP_W'(1);
          if (gap_end) begin
            gap_cnt <= '0;
            if (kind == XK_CFG) begin
              st <= ST_IDLE;
            end else if (chain_fill) begin
              chain_fill <= 1'b0;
              kind       <= XK_FILL;
              left       <= CNT_W'(size_q);
              addr_q     <= '0;
              hdr_idx    <= '0;
              cs_q       <= 1'b0;
              st         <= ST_XFER;
            end else begin
              st     <= ST_IDLE;
              done_q <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign cmd_ready  = (st == ST_IDLE);
  assign busy       = !cmd_ready;
  assign done       = done_q;
  assign wr_ready   = wr_rdy_c;
  assign rd_valid   = rdv_q;
  assign rd_data    = rdd_q;
  assign size_bytes = size_q;
  assign cs_n       = cs_q;
  assign sh_start   = start_c;
  assign sh_tx      = in_hdr ? hdr_byte : dat_byte;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R10
  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> cs_q); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdv_q && !rd_ready) |=> (rdv_q && $stable(rdd_q))); // R6
  AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_rdy_c) |-> !cs_q); // R5
  AST_NO_START_WHILE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    sh_active |-> !start_c); // R3

endmodule

// File: rtl/spi_sram_ctrl.sv
module spi_sram_ctrl #(
  parameter int         CLK_DIV    = 2,
  parameter int         LEN_W      = 17,
  parameter int         UNIT_LOG2  = 13,
  parameter logic [7:0] OPC_READ   = 8'h03,
  parameter logic [7:0] OPC_WRITE  = 8'h02,
  parameter logic [7:0] OPC_WRSR   = 8'h01,
  parameter logic [7:0] OPC_MODEID = 8'h15,
  parameter logic [7:0] CFG_VALUE  = 8'h41
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [1:0]           cmd_op,
  input  logic [15:0]          cmd_addr,
  input  logic [LEN_W-1:0]     cmd_len,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [7:0]           wr_data,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [7:0]           rd_data,
  output logic                 busy,
  output logic                 done,
  output logic [UNIT_LOG2+3:0] size_bytes,
  output logic                 sclk,
  output logic                 mosi,
  input  logic                 miso,
  output logic                 cs_n
);

  logic       sh_start;
  logic [7:0] sh_tx;
  logic       sh_active;
  logic       sh_done;
  logic [7:0] sh_rx;

  spisram_seq #(
    .CLK_DIV    (CLK_DIV),
    .LEN_W      (LEN_W),
    .UNIT_LOG2  (UNIT_LOG2),
    .OPC_READ   (OPC_READ),
    .OPC_WRITE  (OPC_WRITE),
    .OPC_WRSR   (OPC_WRSR),
    .OPC_MODEID (OPC_MODEID),
    .CFG_VALUE  (CFG_VALUE)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_len    (cmd_len),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_data    (wr_data),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_data    (rd_data),
    .busy       (busy),
    .done       (done),
    .size_bytes (size_bytes),
    .cs_n       (cs_n),
    .sh_start   (sh_start),
    .sh_tx      (sh_tx),
    .sh_active  (sh_active),
    .sh_done    (sh_done),
    .sh_rx      (sh_rx)
  );

  spisram_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (sh_start),
    .tx_byte   (sh_tx),
    .miso      (miso),
    .sclk      (sclk),
    .mosi      (mosi),
    .rx_byte   (sh_rx),
    .byte_done (sh_done),
    .active    (sh_active)
  );

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R4
  AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> !cs_n); // R4

endmodule

// File: tb/sim_spi_sram_ctrl.sv
module sim_spi_sram_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int LW         = 8;
  localparam int ULOG       = 4;
  localparam int MEMN       = 1024;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic [1:0]      cmd_op = 2'd0;
  logic [15:0]     cmd_addr = '0;
  logic [LW-1:0]   cmd_len = '0;
  logic            wr_valid = 1'b0;
  logic            wr_ready;
  logic [7:0]      wr_data = '0;
  logic            rd_valid;
  logic            rd_ready = 1'b0;
  logic [7:0]      rd_data;
  logic            busy;
  logic            done;
  logic [ULOG+3:0] size_bytes;
  logic            sclk;
  logic            mosi;
  logic            miso = 1'b0;
  logic            cs_n;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_sram_ctrl #(.CLK_DIV(DIV), .LEN_W(LW), .UNIT_LOG2(ULOG)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .done(done), .size_bytes(size_bytes),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  // ---------------- memory model ----------------
  logic [7:0]  mem [0:MEMN-1];
  logic [7:0]  exp_mem [0:MEMN-1];
  logic [7:0]  status = 8'h00;
  logic [7:0]  model_code = 8'h00;
  logic [7:0]  in_sh = 8'h00, out_sh = 8'hFF, out_next = 8'hFF, op = 8'h00;
  logic [7:0]  txlog [0:3];
  logic [15:0] maddr = '0;
  logic        load = 1'b0;
  int bitcnt = 0, bytecnt = 0, win_cnt = 0, empty_win = 0, last_bits = 0;
  int first_bits = -1, dummy_nz = 0;

  always @(negedge cs_n) begin
    bitcnt = 0; bytecnt = 0; load = 1'b0;
  end

  always @(posedge cs_n) begin
    win_cnt++;
    last_bits = bitcnt;
    if (bitcnt == 0) empty_win++;
    if (win_cnt == 1) first_bits = bitcnt;
  end

  always @(posedge sclk) begin
    if (cs_n == 1'b0) begin
      in_sh = {in_sh[6:0], mosi};
      bitcnt++;
      if (bitcnt % 8 == 0) begin
        if (bytecnt < 4) txlog[bytecnt] = in_sh;
        if (bytecnt == 0) begin
          op = in_sh;
          if (op == 8'h15) begin out_next = model_code; load = 1'b1; end
        end else if (bytecnt == 1) begin
          maddr[15:8] = in_sh;
          if (op == 8'h01) status = in_sh;
        end else if (bytecnt == 2) begin
          maddr[7:0] = in_sh;
          if (op == 8'h03) begin out_next = mem[maddr[9:0]]; load = 1'b1; maddr++; end
        end else begin
          if (op == 8'h02) begin mem[maddr[9:0]] = in_sh; maddr++; end
          else if (op == 8'h03) begin
            if (in_sh != 8'h00) dummy_nz++;
            out_next = mem[maddr[9:0]]; load = 1'b1; maddr++;
          end
        end
        bytecnt++;
      end
    end
  end

  always @(negedge sclk) begin
    if (cs_n == 1'b0) begin
      if (load) begin out_sh = out_next; load = 1'b0; end
      miso = out_sh[7];
      out_sh = {out_sh[6:0], 1'b0};
    end
  end

  // ---------------- link timing monitors ----------------
  int hi_run = 0, bad_hi = 0, hi_seen = 0, cs_run = 0, bad_gap = 0, done_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (sclk) hi_run++;
      else if (hi_run > 0) begin
        hi_seen++;
        if (hi_run != DIV) bad_hi++;
        hi_run = 0;
      end
      if (cs_n) cs_run++;
      else if (cs_run > 0) begin
        if (cs_run < 2 * DIV) bad_gap++;
        cs_run = 0;
      end
    end
  end

  // ---------------- checking helpers ----------------
  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int i);
    return 8'((a * 3 + i * 29 + 7) & 255);
  endfunction

  task automatic issue(input logic [1:0] o, input logic [15:0] a, input int n);
    @(negedge clk);
    cmd_op = o; cmd_addr = a; cmd_len = LW'(n); cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    while (done_cnt == d0) @(negedge clk);
  endtask

  task automatic feed(input int a, input int n);
    for (int i = 0; i < n; i++) begin
      if (i % 2 == 1) begin
        wr_valid = 1'b0;
        repeat (20) @(negedge clk);
      end
      wr_data = pat(a, i);
      wr_valid = 1'b1;
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
    end
    wr_valid = 1'b0;
  endtask

  task automatic do_write(input int a, input int n);
    int d0, w0;
    d0 = done_cnt; w0 = win_cnt;
    issue(2'd1, 16'(a), n);
    feed(a, n);
    wait_done(d0);
    for (int i = 0; i < n; i++) exp_mem[(a + i) % MEMN] = pat(a, i);
    check(win_cnt == w0 + 1, "R5", "write windows", win_cnt - w0, 1);
    check(last_bits == 24 + 8 * n, n == 0 ? "R7" : "R5", "write bits", last_bits, 24 + 8 * n);
    check(txlog[0] == 8'h02 && txlog[1] == 8'(a >> 8) && txlog[2] == 8'(a),
          "R5", "write header opcode", int'(txlog[0]), 2);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < MEMN; i++) if (mem[i] !== exp_mem[i]) bad++;
      check(bad == 0, "R5", "memory cells differing after write", bad, 0);
    end
  endtask

  task automatic do_read(input int a, input int n);
    int d0, bad;
    d0 = done_cnt; bad = 0;
    issue(2'd0, 16'(a), n);
    for (int i = 0; i < n; i++) begin
      while (!rd_valid) @(negedge clk);
      if (rd_data !== exp_mem[(a + i) % MEMN]) begin
        bad++;
        $display("FAIL R6 read byte %0d: actual=%0d expected=%0d", i, rd_data,
                 exp_mem[(a + i) % MEMN]);
      end
      if (i % 2 == 0) repeat (40) @(negedge clk);
      check(rd_valid == 1'b1, "R6", "rd_valid held while stalled", rd_valid, 1);
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
    end
    wait_done(d0);
    check(bad == 0, "R6", "read bytes wrong", bad, 0);
    check(last_bits == 24 + 8 * n, n == 0 ? "R7" : "R6", "read bits", last_bits, 24 + 8 * n);
    check(txlog[0] == 8'h03, "R6", "read opcode", int'(txlog[0]), 3);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog expired: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    for (int i = 0; i < MEMN; i++) begin
      mem[i] = 8'((i * 5 + 1) & 255);
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    win_cnt = 0; empty_win = 0; first_bits = -1;
    // R1 reset state
    check(cs_n == 1'b1 && sclk == 1'b0, "R1", "cs_n/sclk in reset", {cs_n, sclk}, 2);
    check(cmd_ready == 1'b0 && done == 1'b0 && rd_valid == 1'b0, "R1", "ready/done/rd in reset",
          {cmd_ready, done, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n == 1'b1 && cmd_ready == 1'b0, "R1", "after release", {cs_n, cmd_ready}, 2);
    while (!cmd_ready) @(negedge clk);
    // R2 init
    check(first_bits == 0 && empty_win == 1, "R2", "idle pulse without clocks", first_bits, 0);
    check(win_cnt == 2, "R2", "init windows", win_cnt, 2);
    check(txlog[0] == 8'h01 && last_bits == 16, "R2", "config opcode", int'(txlog[0]), 1);
    check(status == 8'h41, "R2", "status value", int'(status), 65);

    // R5/R6/R7 sweep over addresses and lengths
    begin
      int addrs [3];
      addrs[0] = 16'h0005; addrs[1] = 16'h12F0; addrs[2] = 16'h03FD;
      for (int ai = 0; ai < 3; ai++) begin
        for (int n = 0; n <= 4; n++) begin
          do_write(addrs[ai], n);
          do_read(addrs[ai], n);
        end
      end
    end
    check(dummy_nz == 0, "R6", "nonzero dummy bytes", dummy_nz, 0);

    // R10 command while busy is ignored
    begin
      int d0, w0;
      d0 = done_cnt; w0 = win_cnt;
      issue(2'd1, 16'h0100, 3);
      fork
        feed(16'h0100, 3);
        begin
          repeat (5) @(negedge clk);
          cmd_op = 2'd2; cmd_valid = 1'b1;
          repeat (30) begin
            @(negedge clk);
            check(cmd_ready == 1'b0 && busy == 1'b1, "R10", "ready while busy", cmd_ready, 0);
          end
          cmd_valid = 1'b0;
        end
      join
      wait_done(d0);
      for (int i = 0; i < 3; i++) exp_mem[(16'h0100 + i) % MEMN] = pat(16'h0100, i);
      repeat (200) @(negedge clk);
      check(win_cnt == w0 + 1, "R10", "windows after ignored command", win_cnt - w0, 1);
      check(done_cnt == d0 + 1, "R10", "done pulses", done_cnt - d0, 1);
      check(cmd_ready == 1'b1, "R10", "ready after done", cmd_ready, 1);
    end

    // R8 size query sweep
    for (int c = 0; c < 6; c++) begin
      int d0, exp;
      model_code = 8'(c);
      d0 = done_cnt;
      issue(2'd2, 16'h0000, 0);
      wait_done(d0);
      exp = (c < 4) ? (16 << c) : 0;
      check(int'(size_bytes) == exp, "R8", "size for code", int'(size_bytes), exp);
      check(txlog[0] == 8'h15 && txlog[1] == 8'hFF && last_bits == 16, "R8",
            "query framing", int'(txlog[0]), 21);
    end

    // R9 clear with 32 bytes, then with size 0
    begin
      int d0, w0, bad;
      model_code = 8'd1;
      d0 = done_cnt; w0 = win_cnt;
      issue(2'd3, 16'hABCD, 5);
      wait_done(d0);
      check(win_cnt == w0 + 2, "R9", "clear windows", win_cnt - w0, 2);
      check(last_bits == 24 + 8 * 32, "R9", "fill bits", last_bits, 24 + 256);
      check(txlog[0] == 8'h02 && txlog[1] == 8'h00 && txlog[2] == 8'h00, "R9",
            "fill address", int'({txlog[1], txlog[2]}), 0);
      bad = 0;
      for (int i = 0; i < 32; i++) if (mem[i] !== 8'h00) bad++;
      check(bad == 0, "R9", "nonzero cells in cleared range", bad, 0);
      check(mem[32] === exp_mem[32], "R9", "cell past cleared range", int'(mem[32]),
            int'(exp_mem[32]));
      check(done_cnt == d0 + 1, "R10", "one done for clear", done_cnt - d0, 1);
      for (int i = 0; i < 32; i++) exp_mem[i] = 8'h00;
      model_code = 8'd9;
      d0 = done_cnt; w0 = win_cnt;
      issue(2'd3, 16'h0000, 0);
      wait_done(d0);
      check(win_cnt == w0 + 2 && last_bits == 24, "R9", "size-zero fill bits", last_bits, 24);
      check(mem[32] === exp_mem[32], "R9", "memory after size-zero clear", int'(mem[32]),
            int'(exp_mem[32]));
    end

    // R3/R4 link timing summary
    check(bad_hi == 0 && hi_seen > 0, "R3", "sclk high phases of wrong length", bad_hi, 0);
    check(bad_gap == 0, "R4", "short select gaps", bad_gap, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule